// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits between a serial bus controller and a byte-wide storage array. The controller opens a write transaction by handing over its start address. It then passes each received data byte with a one-cycle strobe. The block parks each byte in a 64-entry page buffer at the current in-page offset and advances that offset modulo the page size, so the upper address bits never change within a transaction.

When the controller signals STOP and at least one byte was received, the block starts one timed program cycle. During that cycle it copies the buffered bytes into the array, one write per clock in ascending offset order, and it holds `busy` for a fixed number of clocks. The controller uses `busy` to ignore its device address while the cycle runs.

A supervisory reset input guards the array. While it is active, no transaction is collected and no cycle starts. Any page data already buffered is dropped. A program cycle that is already running is not interrupted by it.

Top module: `page_prog_seq`

## Requirements
- R1: After `rst_n` is released, and before any stimulus, `busy` and `mem_we` are 0.
- R2: The N-th byte (N counting from 0) after `wr_begin` is stored at offset (start_addr[5:0] + N) mod 64 and written to address {start_addr[ADDR_W-1:6], offset}. The upper bits never change within a page.
- R3: When more than 64 bytes arrive before STOP, a later byte replaces the earlier byte at the same offset. Only the last value at each offset is written.
- R4: A STOP with no byte received since the last `wr_begin` starts no program cycle. A STOP after at least one byte raises `busy` in the cycle following the STOP strobe.
- R5: During a program cycle, exactly the offsets that received a byte are written, once each, in ascending offset order.
- R6: `busy` stays high for exactly CYCLE_CLKS clock cycles, and `mem_we` is only ever high while `busy` is high.
- R7: While `busy` is high, `wr_begin`, `byte_stb` and `stop` are ignored. A STOP sent after the cycle, with no new `wr_begin`, starts nothing.
- R8: While `sup_rst` is high, bytes are not collected and a STOP starts no cycle. Bytes buffered before `sup_rst` are discarded, so a later STOP starts nothing.
- R9: Raising `sup_rst` during a program cycle neither shortens it nor suppresses any of its writes.
- R10: A new `wr_begin` clears the buffer. Bytes from an earlier transaction that ended without STOP are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low logic reset |
| sup_rst | input | 1 | Supply supervisor reset active (write protect) |
| wr_begin | input | 1 | Pulse: write transaction opened, start_addr valid |
| start_addr | input | ADDR_W | First byte address of the transaction |
| byte_stb | input | 1 | Pulse: one data byte received |
| byte_data | input | DATA_W | Received data byte |
| stop | input | 1 | Pulse: STOP condition seen on the bus |
| busy | output | 1 | Program cycle running |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
Two events can meet in a running program cycle: the supervisory reset, and a fresh transaction (begin, bytes and STOP) from the controller. The bench provokes both at a chosen cycle count inside `busy`. It judges them by the length of `busy` and by the exact sequence of array writes against a page model. It then confirms that a STOP after the cycle ends starts nothing. It also applies the reset across collection, both before and after bytes arrive, and expects no cycle at the following STOP.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int CYCLE_CLKS = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_rst,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS + PAGE + 1);

  logic [DATA_W-1:0]        pbuf [PAGE];
  logic [PAGE-1:0]          pvld;
  logic [PAGE_W-1:0]        ptr;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic                     armed;
  logic [CNT_W-1:0]         cnt;
  logic [PAGE_W-1:0]        idx;

  assign idx       = cnt[PAGE_W-1:0];
  assign mem_we    = busy && (cnt < CNT_W'(PAGE)) && pvld[idx];
  assign mem_addr  = {base, idx};
  assign mem_wdata = pbuf[idx];

  always_ff @(posedge clk) begin
    if (!busy && !sup_rst && !stop && !wr_begin && byte_stb && armed)
      pbuf[ptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvld  <= '0;
      ptr   <= '0;
      base  <= '0;
      armed <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(CYCLE_CLKS - 1)) begin
        busy <= 1'b0;
        cnt  <= '0;
        pvld <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (sup_rst) begin
      armed <= 1'b0;
      pvld  <= '0;
    end else if (stop) begin
      armed <= 1'b0;
      if (armed && |pvld) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else begin
        pvld <= '0;
      end
    end else if (wr_begin) begin
      armed <= 1'b1;
      pvld  <= '0;
      base  <= start_addr[ADDR_W-1:PAGE_W];
      ptr   <= start_addr[PAGE_W-1:0];
    end else if (byte_stb && armed) begin
      pvld[ptr] <= 1'b1;
      ptr       <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/page_prog_seq_chk.sv
module page_prog_seq_chk #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_W     = 6,
  parameter int CYCLE_CLKS = 500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sup_rst,
  input logic              stop,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [31:0] blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blen <= '0;
    else        blen <= busy ? blen + 1 : '0;
  end

  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blen == CYCLE_CLKS);

  p_start_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop) && !$past(sup_rst));

  p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]));

  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0]));
endmodule

bind page_prog_seq page_prog_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .stop(stop),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_page_prog_seq.sv
module test_page_prog_seq;
  localparam int AW = 12, DW = 8, PW = 6, CYC = 80, PAGE = 64;

  logic clk = 0, rst_n = 0, sup_rst = 0, wr_begin = 0, byte_stb = 0, stop = 0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  page_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .CYCLE_CLKS(CYC)) i_page_prog_seq (
    .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .wr_begin(wr_begin),
    .start_addr(start_addr), .byte_stb(byte_stb), .byte_data(byte_data),
    .stop(stop), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, bl = 0;
  bit done = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  bit            mv[PAGE];
  logic [DW-1:0] md[PAGE];
  logic [AW-PW-1:0] mbase;
  logic [PW-1:0] mptr;

  always @(negedge clk) begin
    if (mem_we) begin qa.push_back(mem_addr); qd.push_back(mem_wdata); end
    if (busy) bl++;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] off_of(logic [AW-1:0] a, int n);
    return PW'((int'(a[PW-1:0]) + n) % PAGE);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < PAGE; i++) mv[i] = 0;
  endtask

  task automatic send_begin(logic [AW-1:0] a, bit track);
    @(negedge clk); wr_begin = 1; start_addr = a;
    @(negedge clk); wr_begin = 0;
    if (track) begin model_clear(); mbase = a[AW-1:PW]; mptr = a[PW-1:0]; end
  endtask

  task automatic send_bytes(int n, bit track);
    for (int i = 0; i < n; i++) begin
      byte_data = DW'($urandom);
      byte_stb = 1;
      if (track) begin mv[mptr] = 1; md[mptr] = byte_data; mptr = mptr + 1'b1; end
      @(negedge clk);
      byte_stb = 0;
    end
  endtask

  task automatic send_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask

  // mode 0 plain, 1 supervisor reset inside busy, 2 traffic inside busy
  task automatic commit_check(bit expect_commit, int mode, string req);
    int k, n, j;
    chk(busy == expect_commit, req, "busy after STOP", busy, expect_commit);
    k = 0;
    while (busy && k < CYC + 10) begin
      if (mode == 1 && k == 10) sup_rst = 1;
      if (mode == 1 && k == 30) sup_rst = 0;
      if (mode == 2 && k == 5) begin wr_begin = 1; start_addr = 12'h000; end
      if (mode == 2 && k == 6) begin wr_begin = 0; byte_stb = 1; byte_data = 8'h5A; end
      if (mode == 2 && k == 8) begin byte_stb = 0; stop = 1; end
      if (mode == 2 && k == 9) stop = 0;
      @(negedge clk); k++;
    end
    sup_rst = 0; wr_begin = 0; byte_stb = 0; stop = 0;
    if (expect_commit) begin
      chk(bl == CYC, (mode == 1) ? "R9" : "R6", "busy length", bl, CYC);
      n = 0;
      for (int o = 0; o < PAGE; o++) if (mv[o]) n++;
      chk(qa.size() == n, (mode == 1) ? "R9" : "R5", "write count", qa.size(), n);
      j = 0;
      for (int o = 0; o < PAGE; o++) if (mv[o] && j < qa.size()) begin
        if (qa[j] != {mbase, PW'(o)} || qd[j] != md[o]) begin
          chk(0, "R2", "write addr/data", int'(qa[j]), int'({mbase, PW'(o)}));
          chk(qd[j] == md[o], "R3", "write data", qd[j], md[o]);
        end
        j++;
      end
      checks++;
    end else begin
      repeat (5) @(negedge clk);
      chk(qa.size() == 0 && bl == 0, req, "no program cycle", qa.size() + bl, 0);
    end
    if (mode == 2) begin
      send_stop();
      repeat (3) @(negedge clk);
      chk(busy == 0, "R7", "STOP after cycle starts nothing", busy, 0);
    end
    qa.delete(); qd.delete(); bl = 0; model_clear();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1640));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && mem_we == 0, "R1", "reset state", busy + mem_we, 0);

    // R2 single byte mid page
    send_begin(12'h7C5, 1); send_bytes(1, 1); send_stop(); commit_check(1, 0, "R4");
    // R2 crossing the page end wraps to offset 0
    send_begin(12'h23E, 1); send_bytes(5, 1); send_stop(); commit_check(1, 0, "R2");
    // R3 overflow: 70 bytes overwrite first six
    send_begin(12'h400, 1); send_bytes(70, 1); send_stop(); commit_check(1, 0, "R3");
    // R4 STOP with no data
    send_begin(12'h100, 0); send_stop(); commit_check(0, 0, "R4");
    // R10 second begin discards first bytes
    send_begin(12'h0C0, 0); send_bytes(3, 0);
    send_begin(12'hA10, 1); send_bytes(2, 1); send_stop(); commit_check(1, 0, "R10");
    // R8 reset after bytes
    send_begin(12'h300, 0); send_bytes(4, 0);
    sup_rst = 1; repeat (3) @(negedge clk); sup_rst = 0;
    send_stop(); commit_check(0, 0, "R8");
    // R8 bytes during reset
    send_begin(12'h340, 0); sup_rst = 1; send_bytes(4, 0); sup_rst = 0;
    send_stop(); commit_check(0, 0, "R8");
    // R8 STOP while reset held
    send_begin(12'h380, 0); send_bytes(2, 0);
    sup_rst = 1; send_stop(); sup_rst = 0; commit_check(0, 0, "R8");
    // R9 reset inside busy
    send_begin(12'h555, 1); send_bytes(40, 1); send_stop(); commit_check(1, 1, "R9");
    // R7 traffic inside busy
    send_begin(12'h900, 1); send_bytes(10, 1); send_stop(); commit_check(1, 2, "R7");

    for (int t = 0; t < 16; t++) begin
      logic [AW-1:0] a;
      int n;
      a = AW'($urandom);
      n = 1 + int'($urandom % 140);
      send_begin(a, 1); send_bytes(n, 1); send_stop();
      commit_check(1, 0, (n > PAGE) ? "R3" : "R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule